// File: doc/BRIEF.md
# FSM Parity-Compaction Concurrent Checker

This block wraps a small fixed finite state machine (four states, two inputs, three Mealy outputs) with an online error detector. Duplicating the machine is not needed. A set of parity trees compresses the five-bit vector made of the next-state and output bits into a few check bits. Each check bit is the XOR of the positions that a bit-mask parameter selects. A separate prediction path computes the expected check bits straight from the present state and input. It works from its own table and not from the machine's logic.

The machine's outputs, its state and the predicted check bits are each registered. The parity trees then operate on the registered state and the held outputs, so a corrupted state register is also seen. A registered comparator raises `err_o` one cycle after the corrupted values reach the hold registers. A fault-injection port forces one chosen vector position to a stuck value, so the detector can be exercised. The masks are supplied as parameters; how they are chosen is not part of the block.

Top module: `fsm_parity_monitor`

## Requirements
- R1: The monitored vector has five bits. Bit 0 and bit 1 are next-state bits 0 and 1, and bits 2, 3 and 4 are output bits 0, 1 and 2. Check bit i is the XOR of the vector bits whose positions are set in `MASKS[i]`. There are between 1 and 5 check bits.
- R2: State encoding is 0..3, with a = `in_i[0]` and b = `in_i[1]`. The next state is state+1 (mod 4) when a=1, state-1 (mod 4) when a=0 and b=1, and unchanged otherwise. The outputs are out0 = (state==3 & a), out1 = state[1] and out2 = state[0]^b. `state_o` and `out_o` show the captured values one clock later.
- R3: Without fault injection, `err_o` never rises.
- R4: A single forced position that changes the vector bit, and that is covered by at least one mask, drives `err_o` to 1. This happens at the second rising edge after the cycle in which the fault is applied.
- R5: A forced position that no mask covers, or a forced value equal to the fault-free bit, leaves `err_o` at 0.
- R6: A fault on a next-state bit is detected, even though it lands in the state register.
- R7: A synchronous active-high `rst` sets the state, the held outputs and the predictions to zero, which is a consistent set. `err_o` is 0 during reset and in the cycles after it.
- R8: With `STICKY`=1, once `err_o` is 1 it stays 1 until reset.
- R9: With `STICKY`=0, `err_o` falls back to 0 once a fault-free transition has passed through the hold registers.
- R10: A fault position of 5 or more has no effect on the vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_i | input | 2 | Machine inputs (bit 0 = a, bit 1 = b) |
| fi_en | input | 1 | Enables the stuck-at override for this transition |
| fi_pos | input | 3 | Vector position to override |
| fi_val | input | 1 | Stuck value forced on that position |
| state_o | output | 2 | Registered state |
| out_o | output | 3 | Held machine outputs |
| err_o | output | 1 | Registered error flag |

## Verification
The bench injects stuck-at faults on every position, with both stuck values, starting from varied states. The fault sometimes agrees with the true bit and sometimes contradicts it. A comparator whose delay is off by one edge would flag the wrong cycle. A design that skipped the state bits would miss every next-state fault. A detector that compared instead of XOR-reducing, or that used the wrong mask, would flag faults it cannot see, or miss faults it should report.

A second instance has one output bit outside its masks and runs in sticky mode. Wrong coverage or a flag that clears early shows up there. Out-of-range fault positions and the cycles straight after reset show any false alarm.

// File: rtl/fsmpm_pkg.sv
package fsmpm_pkg;
  localparam int ST_W  = 2;
  localparam int OUT_W = 3;
  localparam int IN_W  = 2;
  localparam int VEC_W = ST_W + OUT_W;
  localparam int POS_W = $clog2(VEC_W);

  typedef logic [VEC_W-1:0] vec_t;
  typedef enum logic [ST_W-1:0] {ST_A = 2'd0, ST_B = 2'd1, ST_C = 2'd2, ST_D = 2'd3} st_e;

  // Expected {out2,out1,out0,ns1,ns0} per index {state,b,a}
  function automatic vec_t spec_vec(input logic [ST_W+IN_W-1:0] idx);
    vec_t v;
    case (idx)
      4'd0:  v = 5'b00000;
      4'd1:  v = 5'b00001;
      4'd2:  v = 5'b10011;
      4'd3:  v = 5'b10001;
      4'd4:  v = 5'b10001;
      4'd5:  v = 5'b10010;
      4'd6:  v = 5'b00000;
      4'd7:  v = 5'b00010;
      4'd8:  v = 5'b01010;
      4'd9:  v = 5'b01011;
      4'd10: v = 5'b11001;
      4'd11: v = 5'b11011;
      4'd12: v = 5'b11011;
      4'd13: v = 5'b11100;
      4'd14: v = 5'b01010;
      default: v = 5'b01100;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/fsmpm_core.sv
module fsmpm_core
  import fsmpm_pkg::*;
(
  input  logic [ST_W-1:0]  state_i,
  input  logic [IN_W-1:0]  in_i,
  input  logic             fi_en,
  input  logic [POS_W-1:0] fi_pos,
  input  logic             fi_val,
  output vec_t             vec_o
);
  logic [ST_W-1:0]  ns;
  logic [OUT_W-1:0] outs;
  logic a, b;
  vec_t raw;

  assign a = in_i[0];
  assign b = in_i[1];

  always_comb begin
    ns   = state_i;
    outs = '0;
    case (st_e'(state_i))
      ST_A: begin
        ns   = a ? ST_B : (b ? ST_D : ST_A);
        outs = {b, 1'b0, 1'b0};
      end
      ST_B: begin
        ns   = a ? ST_C : (b ? ST_A : ST_B);
        outs = {~b, 1'b0, 1'b0};
      end
      ST_C: begin
        ns   = a ? ST_D : (b ? ST_B : ST_C);
        outs = {b, 1'b1, 1'b0};
      end
      default: begin
        ns   = a ? ST_A : (b ? ST_C : ST_D);
        outs = {~b, 1'b1, a};
      end
    endcase
  end

  assign raw = {outs, ns};

  // Stuck-at override on one selected position
  always_comb begin
    vec_o = raw;
    for (int j = 0; j < VEC_W; j++)
      if (fi_en && (fi_pos == POS_W'(j)))
        vec_o[j] = fi_val;
  end
endmodule

// File: rtl/fsmpm_predict.sv
module fsmpm_predict
  import fsmpm_pkg::*;
#(
  parameter int L = 3,
  parameter logic [L-1:0][VEC_W-1:0] MASKS = '1
)(
  input  logic [ST_W-1:0] state_i,
  input  logic [IN_W-1:0] in_i,
  output logic [L-1:0]    pred_o
);
  vec_t expv;
  assign expv = spec_vec({state_i, in_i});

  for (genvar i = 0; i < L; i++) begin : g_pred
    assign pred_o[i] = ^(expv & MASKS[i]);
  end
endmodule

// File: rtl/fsmpm_compact.sv
module fsmpm_compact
  import fsmpm_pkg::*;
#(
  parameter int L = 3,
  parameter logic [L-1:0][VEC_W-1:0] MASKS = '1
)(
  input  vec_t         held_i,
  input  logic [L-1:0] pred_i,
  output logic         mismatch_o
);
  logic [L-1:0] actual;

  for (genvar i = 0; i < L; i++) begin : g_tree
    assign actual[i] = ^(held_i & MASKS[i]);
  end

  assign mismatch_o = |(actual ^ pred_i);
endmodule

// File: rtl/fsm_parity_monitor.sv
module fsm_parity_monitor
  import fsmpm_pkg::*;
#(
  parameter int L = 3,
  parameter logic [L-1:0][VEC_W-1:0] MASKS = {5'b11011, 5'b01110, 5'b10101},
  parameter bit STICKY = 1'b0
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  in_i,
  input  logic             fi_en,
  input  logic [POS_W-1:0] fi_pos,
  input  logic             fi_val,
  output logic [ST_W-1:0]  state_o,
  output logic [OUT_W-1:0] out_o,
  output logic             err_o
);
  logic [ST_W-1:0]  state_q;
  logic [OUT_W-1:0] out_q;
  logic [L-1:0]     pred_q;
  logic [L-1:0]     pred_d;
  logic             err_q;
  logic             mismatch;
  vec_t             vec_d;

  fsmpm_core u_core (
    .state_i(state_q), .in_i(in_i), .fi_en(fi_en),
    .fi_pos(fi_pos), .fi_val(fi_val), .vec_o(vec_d)
  );

  fsmpm_predict #(.L(L), .MASKS(MASKS)) u_pred (
    .state_i(state_q), .in_i(in_i), .pred_o(pred_d)
  );

  fsmpm_compact #(.L(L), .MASKS(MASKS)) u_cmp (
    .held_i({out_q, state_q}), .pred_i(pred_q), .mismatch_o(mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      out_q   <= '0;
      pred_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= vec_d[ST_W-1:0];
      out_q   <= vec_d[VEC_W-1:ST_W];
      pred_q  <= pred_d;
      err_q   <= mismatch | (STICKY & err_q);
    end
  end

  assign state_o = state_q;
  assign out_o   = out_q;
  assign err_o   = err_q;
endmodule

// File: rtl/fsm_parity_monitor_sva.sv
module fsm_parity_monitor_sva #(
  parameter bit STICKY = 1'b0
)(
  input logic clk,
  input logic rst,
  input logic fi_en,
  input logic err_o
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !err_o); // R7
  AST_NO_FALSE_ALARM: assert property (@(posedge clk) disable iff (rst)
    (!STICKY && !fi_en) |=> ##1 !err_o); // R3
  AST_RISE_FROM_FAULT: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> $past(fi_en, 2)); // R4
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (STICKY && err_o) |=> err_o); // R8
  AST_CLEAR_AFTER: assert property (@(posedge clk) disable iff (rst)
    (!STICKY && err_o && !$past(fi_en)) |=> !err_o); // R9
endmodule

bind fsm_parity_monitor fsm_parity_monitor_sva #(.STICKY(STICKY)) u_sva (
  .clk(clk), .rst(rst), .fi_en(fi_en), .err_o(err_o)
);

// File: tb/fsm_parity_monitor_tb.sv
module fsm_parity_monitor_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic [1:0] in_r = '0;
  logic       fi_en = 1'b0;
  logic [2:0] fi_pos = '0;
  logic       fi_val = 1'b0;
  logic [1:0] stA, stB;
  logic [2:0] outA, outB;
  logic       errA, errB;
  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  localparam logic [2:0][4:0] MA = {5'b11011, 5'b01110, 5'b10101};
  localparam logic [1:0][4:0] MB = {5'b01100, 5'b00011};

  fsm_parity_monitor #(.L(3), .MASKS(MA), .STICKY(1'b0)) u_dut (
    .clk(clk), .rst(rst), .in_i(in_r), .fi_en(fi_en), .fi_pos(fi_pos),
    .fi_val(fi_val), .state_o(stA), .out_o(outA), .err_o(errA));

  fsm_parity_monitor #(.L(2), .MASKS(MB), .STICKY(1'b1)) u_dut_sticky (
    .clk(clk), .rst(rst), .in_i(in_r), .fi_en(fi_en), .fi_pos(fi_pos),
    .fi_val(fi_val), .state_o(stB), .out_o(outB), .err_o(errB));

  function automatic logic [4:0] gold(int s, logic a, logic b);
    int ns;
    logic o0, o1, o2;
    if (a) ns = (s + 1) % 4;
    else if (b) ns = (s + 3) % 4;
    else ns = s;
    o0 = (s == 3) && a;
    o1 = (s >= 2);
    o2 = ((s % 2) == 1) ^ b;
    return {o2, o1, o0, 2'(ns)};
  endfunction

  function automatic logic [2:0] parA(logic [4:0] v);
    logic [2:0] r;
    for (int i = 0; i < 3; i++) r[i] = ^(v & MA[i]);
    return r;
  endfunction

  function automatic logic [1:0] parB(logic [4:0] v);
    logic [1:0] r;
    for (int i = 0; i < 2; i++) r[i] = ^(v & MB[i]);
    return r;
  endfunction

  // Reference model
  logic [1:0] ms = '0;
  logic [2:0] mo = '0;
  logic [2:0] mpA = '0;
  logic [1:0] mpB = '0;
  logic       meA = 1'b0, meB = 1'b0;

  always @(posedge clk) begin
    logic [4:0] g, f, hv;
    if (rst) begin
      ms <= '0; mo <= '0; mpA <= '0; mpB <= '0; meA <= 1'b0; meB <= 1'b0;
    end else begin
      g  = gold(int'(ms), in_r[0], in_r[1]);
      f  = g;
      if (fi_en && fi_pos < 3'd5) f[fi_pos] = fi_val;
      hv = {mo, ms};
      meA <= (parA(hv) != mpA);
      meB <= (parB(hv) != mpB) | meB;
      ms  <= f[1:0];
      mo  <= f[4:2];
      mpA <= parA(g);
      mpB <= parB(g);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(stA == ms, "R2 state", stA, ms);
      chk(outA == mo, "R2 outputs", outA, mo);
      chk(stB == ms, "R2 state sticky inst", stB, ms);
      chk(errA == meA, "R1 parity compare", errA, meA);
      chk(errB == meB, "R1 parity compare sticky inst", errB, meB);
    end
  end

  task automatic rand_step();
    @(negedge clk);
    fi_en = 1'b0;
    in_r  = 2'($urandom_range(0, 3));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(stA == 2'd0 && outA == 3'd0, "R7 reset state", {stA, outA}, 0);
    chk(errA == 1'b0 && errB == 1'b0, "R7 reset err", {errA, errB}, 0);
    rst = 1'b0;
    cmp_en = 1'b1;
    // R3: fault-free run
    for (int c = 0; c < 60; c++) begin
      rand_step();
      chk(errA == 1'b0 && errB == 1'b0, "R3 no false alarm", {errA, errB}, 0);
    end
    // Single stuck-at trials
    for (int pos = 0; pos < 7; pos++) begin
      for (int v = 0; v < 2; v++) begin
        logic [4:0] g;
        bit detA, detB;
        @(negedge clk); rst = 1'b1; fi_en = 1'b0;
        @(negedge clk); rst = 1'b0;
        chk(errA == 1'b0 && errB == 1'b0, "R7 quiet after reset", {errA, errB}, 0);
        repeat (1 + (pos + v) % 4) rand_step();
        @(negedge clk);
        in_r   = 2'($urandom_range(0, 3));
        fi_en  = 1'b1;
        fi_pos = 3'(pos);
        fi_val = v[0];
        g = gold(int'(ms), in_r[0], in_r[1]);
        detA = (pos < 5) && (g[pos] != v[0]);
        detB = detA && (pos != 4);
        rand_step();
        @(negedge clk);
        fi_en = 1'b0;
        in_r  = 2'($urandom_range(0, 3));
        if (pos < 2)
          chk(errA == detA, "R6 state bit fault", errA, detA);
        else if (pos < 5)
          chk(errA == detA, "R4 output bit fault", errA, detA);
        else
          chk(errA == 1'b0, "R10 out-of-range position", errA, 0);
        chk(errB == detB, "R5 coverage and matching value", errB, detB);
        @(negedge clk);
        chk(errA == 1'b0, "R9 non-sticky clears", errA, 0);
        chk(errB == detB, "R8 sticky holds", errB, detB);
      end
    end
    rand_step();
    cmp_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule